// File: doc/BRIEF.md
# Configurable-Trigger NMI Interrupt Controller

This block conditions a single external non-maskable interrupt pin for a parent interrupt controller. The pin is brought into the clock domain through a two-flop synchronizer. A trigger detector then recognises one of four conditions on the synchronized signal: level active-low, falling edge, level active-high or rising edge. A detected condition sets a sticky pending flag. The flag is gated by an enable bit and leaves the block as one registered interrupt line.

Software uses three registers on a simple single-cycle read/write port. It picks the trigger condition in a control word. It reads the pending flag and clears it by writing a one, both to acknowledge an edge and to signal end of interrupt on a level. It masks or unmasks the output through an enable word. A parameter selects one of two address maps, which differ only in where the enable word sits. In level modes the flag sets again right after a clear if the pin is still active. This makes the end-of-interrupt write safe.

Top module: `nmi_trigger_ctrl`

## Requirements
- R1: After reset the control word, the pending flag, the enable bit, `reg_rdata` and `irq_out` are all zero, so the trigger mode is level active-low (code 0).
- R2: The control word is at offset 0x00. All DATA_W bits read back exactly as written, and bits [1:0] select the trigger mode.
- R3: With mode code 0 (level active-low), the pending flag is set in every cycle in which the synchronized input is 0.
- R4: With mode code 1 (falling edge), the pending flag is set only when the synchronized input goes from 1 to 0. A steady low sets nothing again after a clear.
- R5: With mode code 2 (level active-high), the pending flag is set in every cycle in which the synchronized input is 1.
- R6: With mode code 3 (rising edge), the pending flag is set only when the synchronized input goes from 0 to 1.
- R7: The pending register is at offset 0x04, and its bit 0 reads as the flag. Writing it with bit 0 = 1 clears the flag. Writing it with bit 0 = 0 leaves the flag unchanged.
- R8: When a trigger condition and a clear write fall in the same cycle, the flag stays set. A level input still active at the end-of-interrupt write therefore leaves the flag at 1.
- R9: The enable bit is bit 0 of the word at offset 0x08 when MAP_VARIANT = 0, or at offset 0x34 when MAP_VARIANT = 1. It reads back in bit 0, and the upper bits read as zero. A value of 1 unmasks the output.
- R10: `irq_out` equals, one cycle later, the AND of the pending flag and the enable bit.
- R11: A pin change driven before rising edge k is seen in the pending flag after edge k+2 and on `irq_out` after edge k+3.
- R12: A read from any other offset returns zero, and a write to any other offset changes no register.
- R13: `reg_rdata` holds the addressed value in the cycle after a cycle with `reg_rd` = 1, and holds zero after a cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| nmi_in | input | 1 | Asynchronous external interrupt pin |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq_out | output | 1 | Registered interrupt to the parent controller |

## Verification
The bench targets the race between a clear write and a new trigger. A design that lets the clear win loses an edge or drops a still-active level at end of interrupt, and the flag then reads 0 where 1 is due. It checks that a steady low in falling-edge mode stays quiet after a clear. A detector that compares against the wrong previous sample would retrigger there, or would miss the edge entirely. It measures the exact latency from the pin to the pending flag and to `irq_out`, which exposes a missing or extra synchronizer stage. It also writes the enable address of the other map variant and expects no effect, which catches a swapped or aliased decode.

// File: rtl/nmi_trig_pkg.sv
// Shared types and address-map helpers for the NMI trigger controller.
// Assumes byte offsets and a single 32-bit-aligned register per offset.
package nmi_trig_pkg;

    // Trigger mode codes; the numeric values are software-visible.
    typedef enum logic [1:0] {
        TRIG_LVL_LO    = 2'd0,
        TRIG_EDGE_FALL = 2'd1,
        TRIG_LVL_HI    = 2'd2,
        TRIG_EDGE_RISE = 2'd3
    } trig_mode_e;

    localparam int unsigned OFS_CTRL = 32'h00;
    localparam int unsigned OFS_PEND = 32'h04;

    // Offset of the enable word for a given map variant.
    function automatic int unsigned enable_offset(input int variant);
        return (variant == 0) ? 32'h08 : 32'h34;
    endfunction

endpackage

// File: rtl/nmi_sync.sv
// Multi-flop synchronizer for one asynchronous bit.
// Assumes STAGES >= 2; all flops reset to RST_VAL (the idle level of the pin).
module nmi_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the pin through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_trigger_detect.sv
// Recognises the selected trigger condition on the synchronized input.
// Level modes look at the current sample; edge modes compare it with the
// sample of the previous cycle. Assumes the input is already synchronous.
module nmi_trigger_detect
    import nmi_trig_pkg::*;
#(
    parameter logic IDLE_VAL = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level_in,
    input  trig_mode_e mode,
    output logic       hit
);
    logic prev_q;

    // Remember last cycle's sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= IDLE_VAL;
        else        prev_q <= level_in;
    end

    // Decode the trigger condition for the active mode.
    always_comb begin
        unique case (mode)
            TRIG_LVL_LO:    hit = ~level_in;
            TRIG_EDGE_FALL: hit = prev_q & ~level_in;
            TRIG_LVL_HI:    hit = level_in;
            TRIG_EDGE_RISE: hit = ~prev_q & level_in;
            default:        hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/nmi_regfile.sv
// Control, pending and enable registers with a single-cycle access port.
// Read data is registered and is zero after a non-read cycle or an
// unmapped read. The pending flag itself lives outside; this block only
// issues a clear request and reflects the flag on reads.
module nmi_regfile
    import nmi_trig_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int MAP_VARIANT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pend,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              en_q,
    output logic              clr_req,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PEND);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(enable_offset(MAP_VARIANT));

    logic sel_ctrl, sel_pend, sel_en;

    // Address decode.
    always_comb begin
        sel_ctrl = (addr == A_CTRL);
        sel_pend = (addr == A_PEND);
        sel_en   = (addr == A_EN);
    end

    assign clr_req = wr & sel_pend & wdata[0];

    // Control word: full width stored so other bits survive read-modify-write.
    always_ff @(posedge clk) begin
        if (!rst_n)               ctrl_q <= '0;
        else if (wr && sel_ctrl)  ctrl_q <= wdata;
    end

    // Enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)             en_q <= 1'b0;
        else if (wr && sel_en)  en_q <= wdata[0];
    end

    // Registered read mux; zero when idle or unmapped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd) begin
            if (sel_ctrl)      rdata <= ctrl_q;
            else if (sel_pend) rdata <= {{(DATA_W-1){1'b0}}, pend};
            else if (sel_en)   rdata <= {{(DATA_W-1){1'b0}}, en_q};
            else               rdata <= '0;
        end else begin
            rdata <= '0;
        end
    end
endmodule

// File: rtl/nmi_trigger_ctrl.sv
// Top of the single-source NMI trigger controller.
// Synchronizes the pin, detects the configured trigger, latches it in a
// sticky pending flag (set wins over clear) and drives a registered,
// maskable interrupt. Assumes the pin idles high and reset is synchronous.
module nmi_trigger_ctrl
    import nmi_trig_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int MAP_VARIANT = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_in,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_out
);
    localparam logic PIN_IDLE = 1'b1;

    logic              pin_sync;
    logic              set_ev;
    logic              clr_req;
    logic              pend_q;
    logic              en_q;
    logic [DATA_W-1:0] ctrl_q;
    trig_mode_e        mode;

    assign mode = trig_mode_e'(ctrl_q[1:0]);

    nmi_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (nmi_in),
        .q_sync  (pin_sync)
    );

    nmi_trigger_detect #(
        .IDLE_VAL (PIN_IDLE)
    ) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (pin_sync),
        .mode     (mode),
        .hit      (set_ev)
    );

    nmi_regfile #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .MAP_VARIANT (MAP_VARIANT)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .rd      (reg_rd),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .pend    (pend_q),
        .ctrl_q  (ctrl_q),
        .en_q    (en_q),
        .clr_req (clr_req),
        .rdata   (reg_rdata)
    );

    // Sticky pending flag; a trigger in the clear cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_q <= 1'b0;
        else if (set_ev)  pend_q <= 1'b1;
        else if (clr_req) pend_q <= 1'b0;
    end

    // Registered masked interrupt output.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= 1'b0;
        else        irq_out <= pend_q & en_q;
    end
endmodule

// File: rtl/nmi_trigger_ctrl_checker.sv
// Property checker for nmi_trigger_ctrl, attached by bind below.
module nmi_trigger_ctrl_checker
    import nmi_trig_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int MAP_VARIANT = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_out,
    input logic              pend,
    input logic              en,
    input logic              set_ev,
    input logic              clr_req,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata
);
    logic mapped;
    assign mapped = (reg_addr == ADDR_W'(OFS_CTRL)) ||
                    (reg_addr == ADDR_W'(OFS_PEND)) ||
                    (reg_addr == ADDR_W'(enable_offset(MAP_VARIANT)));

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!irq_out && !pend && reg_rdata == '0));

    assert_irq_gating_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_out == $past(pend & en)));

    assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(clr_req && !set_ev)) |-> !pend);

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(set_ev)) |-> pend);

    assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(reg_rd && !mapped)) |-> (reg_rdata == '0));

    assert_idle_rdata_R13: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(reg_rd)) |-> (reg_rdata == '0));
endmodule

bind nmi_trigger_ctrl nmi_trigger_ctrl_checker #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .MAP_VARIANT (MAP_VARIANT)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_out   (irq_out),
    .pend      (pend_q),
    .en        (en_q),
    .set_ev    (set_ev),
    .clr_req   (clr_req),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata)
);

// File: tb/tb_nmi_trigger_ctrl.sv
module tb_nmi_trigger_ctrl;
    localparam int  CLK_PERIOD = 10;
    localparam int  AW = 8;
    localparam int  DW = 32;
    localparam int  VARIANT = 1;
    localparam logic [AW-1:0] A_CTRL  = 8'h00;
    localparam logic [AW-1:0] A_PEND  = 8'h04;
    localparam logic [AW-1:0] A_EN    = 8'h34;
    localparam logic [AW-1:0] A_OTHER = 8'h08;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          nmi_in = 1'b1;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nmi_trigger_ctrl #(.ADDR_W(AW), .DATA_W(DW), .MAP_VARIANT(VARIANT)) dut (
        .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    // Expected behaviour built from the requirements.
    function automatic logic trig_hit(input logic [1:0] m, input logic cur, input logic prv);
        case (m)
            2'd0:    return ~cur;
            2'd1:    return prv & ~cur;
            2'd2:    return cur;
            default: return ~prv & cur;
        endcase
    endfunction

    function automatic logic [DW-1:0] read_value(input logic [AW-1:0] a, input logic [DW-1:0] c,
                                                 input logic p, input logic e);
        if (a == A_CTRL) return c;
        if (a == A_PEND) return {31'd0, p};
        if (a == A_EN)   return {31'd0, e};
        return '0;
    endfunction

    logic          m_s1, m_s2, m_prev, m_pend, m_en, m_irq;
    logic [DW-1:0] m_ctrl, m_rdata;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= 1'b1; m_s2 <= 1'b1; m_prev <= 1'b1;
            m_pend <= 1'b0; m_en <= 1'b0; m_irq <= 1'b0;
            m_ctrl <= '0; m_rdata <= '0;
        end else begin
            m_s1 <= nmi_in; m_s2 <= m_s1; m_prev <= m_s2;
            if (trig_hit(m_ctrl[1:0], m_s2, m_prev)) m_pend <= 1'b1;
            else if (reg_wr && reg_addr == A_PEND && reg_wdata[0]) m_pend <= 1'b0;
            m_irq <= m_pend & m_en;
            if (reg_wr && reg_addr == A_CTRL) m_ctrl <= reg_wdata;
            if (reg_wr && reg_addr == A_EN)   m_en <= reg_wdata[0];
            m_rdata <= reg_rd ? read_value(reg_addr, m_ctrl, m_pend, m_en) : '0;
        end
    end

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model (R10, R13).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R10 irq_out", {31'd0, irq_out}, {31'd0, m_irq});
            chk("R13 reg_rdata", reg_rdata, m_rdata);
        end
    end

    task automatic wr_reg(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [AW-1:0] a, output logic [DW-1:0] v);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); v = reg_rdata; reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] v;
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_reg(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
        rd_reg(A_PEND, v); chk("R1 pend", v, 32'h0);
        rd_reg(A_EN, v);   chk("R1 enable", v, 32'h0);
        chk("R1 irq", {31'd0, irq_out}, 32'h0);

        // R2: full-width control readback, mode 1
        wr_reg(A_CTRL, 32'hA5C3_0F01);
        rd_reg(A_CTRL, v); chk("R2 ctrl readback", v, 32'hA5C3_0F01);

        // R4: falling edge
        nmi_in = 1'b1; idle(4); wr_reg(A_PEND, 32'h1);
        rd_reg(A_PEND, v); chk("R4 quiet high", v, 32'h0);
        nmi_in = 1'b0; idle(4);
        rd_reg(A_PEND, v); chk("R4 falling sets", v, 32'h1);
        // R7: writing zero keeps flag
        wr_reg(A_PEND, 32'hFFFF_FFFE);
        rd_reg(A_PEND, v); chk("R7 write zero ignored", v, 32'h1);
        wr_reg(A_PEND, 32'h1);
        rd_reg(A_PEND, v); chk("R4 steady low no retrigger", v, 32'h0);
        nmi_in = 1'b1; idle(4);
        rd_reg(A_PEND, v); chk("R4 rising ignored", v, 32'h0);

        // R3 and R8: level low
        wr_reg(A_CTRL, 32'h0000_0000); idle(2); wr_reg(A_PEND, 32'h1);
        rd_reg(A_PEND, v); chk("R3 high idle", v, 32'h0);
        nmi_in = 1'b0; idle(4);
        rd_reg(A_PEND, v); chk("R3 low sets", v, 32'h1);
        wr_reg(A_PEND, 32'h1);
        rd_reg(A_PEND, v); chk("R8 set beats clear", v, 32'h1);
        nmi_in = 1'b1; idle(4); wr_reg(A_PEND, 32'h1);
        rd_reg(A_PEND, v); chk("R7 clear works", v, 32'h0);

        // R5: level high
        nmi_in = 1'b0; wr_reg(A_CTRL, 32'h0000_0002); idle(4); wr_reg(A_PEND, 32'h1);
        rd_reg(A_PEND, v); chk("R5 low idle", v, 32'h0);
        nmi_in = 1'b1; idle(4);
        rd_reg(A_PEND, v); chk("R5 high sets", v, 32'h1);

        // R6: rising edge
        nmi_in = 1'b0; wr_reg(A_CTRL, 32'h0000_0003); idle(4); wr_reg(A_PEND, 32'h1);
        rd_reg(A_PEND, v); chk("R6 low idle", v, 32'h0);
        nmi_in = 1'b1; idle(4);
        rd_reg(A_PEND, v); chk("R6 rising sets", v, 32'h1);
        wr_reg(A_PEND, 32'h1);
        rd_reg(A_PEND, v); chk("R6 steady high no retrigger", v, 32'h0);

        // R12: other variant's enable offset is unmapped
        wr_reg(A_OTHER, 32'h1);
        rd_reg(A_OTHER, v); chk("R12 unmapped read", v, 32'h0);
        rd_reg(A_EN, v);    chk("R12 enable untouched", v, 32'h0);
        rd_reg(A_CTRL, v);  chk("R12 ctrl untouched", v, 32'h3);

        // R9: enable readback, upper bits zero
        wr_reg(A_EN, 32'hFFFF_FFFF);
        rd_reg(A_EN, v); chk("R9 enable readback", v, 32'h1);

        // R11: latency pin -> irq (mode 2, enabled)
        wr_reg(A_CTRL, 32'h2); nmi_in = 1'b0; idle(4); wr_reg(A_PEND, 32'h1); idle(2);
        chk("R11 irq low before", {31'd0, irq_out}, 32'h0);
        @(negedge clk); nmi_in = 1'b1;
        @(negedge clk); chk("R11 after k", {31'd0, irq_out}, 32'h0);
        @(negedge clk); chk("R11 after k+1", {31'd0, irq_out}, 32'h0);
        @(negedge clk); chk("R11 after k+2", {31'd0, irq_out}, 32'h0);
        @(negedge clk); chk("R11 after k+3", {31'd0, irq_out}, 32'h1);

        // R10: masking drops irq one cycle after enable clears
        @(negedge clk); reg_wr = 1'b1; reg_addr = A_EN; reg_wdata = 32'h0;
        @(negedge clk); reg_wr = 1'b0; chk("R10 still high", {31'd0, irq_out}, 32'h1);
        @(negedge clk); chk("R10 masked", {31'd0, irq_out}, 32'h0);

        // Random phase, checked every cycle against the model.
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if ($urandom_range(3) == 0) nmi_in = ~nmi_in;
            reg_wr = 1'b0; reg_rd = 1'b0;
            case ($urandom_range(5))
                0: reg_addr = A_CTRL;
                1, 2: reg_addr = A_PEND;
                3: reg_addr = A_EN;
                4: reg_addr = A_OTHER;
                default: reg_addr = AW'($urandom);
            endcase
            reg_wdata = $urandom;
            case ($urandom_range(3))
                0: reg_wr = 1'b1;
                1: reg_rd = 1'b1;
                default: ;
            endcase
        end
        @(negedge clk); reg_wr = 1'b0; reg_rd = 1'b0;
        idle(3);
        finish_run();
    end
endmodule